// File: doc/BRIEF.md
# End-of-Discharge Voltage Monitor

This block watches a stream of 8-bit battery-voltage samples and raises two warnings as the battery nears empty. Each sample code stands for a voltage of 1.2 V × code / 256. The block compares every valid sample against two thresholds. The first is a programmable 8-bit level that resets to A2h, about 0.76 V. The second sits a fixed 21 codes (about 100 mV) lower, and it is clamped at zero.

A warning is not raised on a single low reading. Each threshold has its own debounce state machine, and that machine needs 8 consecutive valid samples strictly below its threshold. With samples every 0.5 s, this spans a 4 s window. Once a warning is raised, it stays raised until the block is reset. Later samples and later threshold writes cannot clear it.

Each debounce machine has three named states:

- `DB_IDLE`: no low sample is pending.
- `DB_COUNT`: one to seven consecutive low samples have been seen.
- `DB_TRIP`: the warning is latched.

The machine moves between them on these transitions:

- `DB_IDLE` goes to `DB_COUNT` on a low valid sample.
- `DB_COUNT` goes back to `DB_IDLE` on a valid sample at or above the threshold.
- `DB_COUNT` goes to `DB_TRIP` on the eighth consecutive low valid sample.
- `DB_TRIP` stays in `DB_TRIP` for every input.

Cycles without a valid strobe leave the state and the count untouched.

Top module: `edv_monitor`

## Requirements
- R1: After reset, `thr_level` reads A2h and both `warn_first` and `warn_final` are 0.
- R2: On a clock edge with `thr_wr` high, `thr_wdata` is loaded and shows on `thr_level` after that edge. A sample taken on the same edge is still compared against the value held before the write.
- R3: The first threshold equals `thr_level`. A sample counts as low for it only when the code is strictly less than `thr_level`, so a code equal to the threshold is not low.
- R4: The final threshold is `thr_level` − 21 when `thr_level` ≥ 21, and 0 otherwise. A sample is low for it only when the code is strictly less than that value, so with a threshold of 0 `warn_final` can never set.
- R5: A warning output goes to 1 right after the clock edge that takes the 8th consecutive low valid sample for its threshold, and not earlier.
- R6: A valid sample at or above a threshold restarts that threshold's count from zero. Cycles with `smp_valid` low neither advance nor clear any count.
- R7: Once set, a warning stays 1 until `rst_n` is driven low, whatever the later samples or threshold writes.
- R8: `warn_final` is never 1 while `warn_first` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Strobe marking a new voltage sample |
| smp_code | input | 8 | Voltage sample code, 1.2 V × code / 256 |
| thr_wr | input | 1 | Host write strobe for the threshold register |
| thr_wdata | input | 8 | Host write data for the threshold register |
| thr_level | output | 8 | Present first-threshold value |
| warn_first | output | 1 | Sticky warning for the first threshold |
| warn_final | output | 1 | Sticky warning for the final threshold |

## Verification
The assertions check several properties on every cycle:

- A latched warning never drops.
- A warning rises only on a cycle that took a low valid sample.
- A debounce count never reaches the trip length.
- A high sample always sends the count back to zero.
- A host write lands in the register.
- The final warning never appears without the first warning.

Some behaviours only the bench's scenarios can show. These are the exact edge on which each warning appears, the strict less-than boundary at code equal to the threshold, and the clamping of the final threshold at zero for thresholds of 21 and below. The bench also shows that a sample taken on the same edge as a write is judged against the old threshold.

// File: rtl/edv_pkg.sv
`timescale 1ns/1ps
package edv_pkg;

    typedef enum logic [1:0] {
        DB_IDLE  = 2'd0,
        DB_COUNT = 2'd1,
        DB_TRIP  = 2'd2
    } db_state_e;

    localparam int LANES = 2;
    localparam int LANE_FIRST = 0;
    localparam int LANE_FINAL = 1;

endpackage

// File: rtl/edv_thr_reg.sv
`timescale 1ns/1ps
module edv_thr_reg #(
    parameter int          CODE_W    = 8,
    parameter logic [7:0]  RST_LEVEL = 8'hA2,
    parameter int          OFFSET    = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CODE_W-1:0] wr_data,
    output logic [CODE_W-1:0] thr_first,
    output logic [CODE_W-1:0] thr_final
);
    localparam logic [CODE_W-1:0] OFS = CODE_W'(OFFSET);
    localparam logic [CODE_W-1:0] RST = CODE_W'(RST_LEVEL);

    logic [CODE_W-1:0] level_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= RST;
        end else if (wr_en) begin
            level_q <= wr_data;
        end
    end

    // Final threshold sits a fixed number of codes below, clamped at zero.
    always_comb begin
        thr_first = level_q;
        if (level_q >= OFS) begin
            thr_final = level_q - OFS;
        end else begin
            thr_final = '0;
        end
    end

    // R2: a host write is visible in the register after the edge.
    p_write_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (thr_first == $past(wr_data)));

    // R4: without a write the register holds its value.
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(thr_first));

endmodule

// File: rtl/edv_debounce.sv
`timescale 1ns/1ps
module edv_debounce
    import edv_pkg::*;
#(
    parameter int TRIP_LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic smp_valid,
    input  logic is_low,
    output logic flag
);
    localparam int CNT_W = (TRIP_LEN > 1) ? $clog2(TRIP_LEN) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TRIP_LEN - 1);

    db_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // Next-state and count logic.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            DB_IDLE: begin
                if (smp_valid && is_low) begin
                    if (TRIP_LEN <= 1) begin
                        state_d = DB_TRIP;
                        cnt_d   = '0;
                    end else begin
                        state_d = DB_COUNT;
                        cnt_d   = CNT_W'(1);
                    end
                end
            end
            DB_COUNT: begin
                if (smp_valid) begin
                    if (!is_low) begin
                        state_d = DB_IDLE;
                        cnt_d   = '0;
                    end else if (cnt_q == LAST) begin
                        state_d = DB_TRIP;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
            end
            DB_TRIP: begin
                state_d = DB_TRIP;
                cnt_d   = '0;
            end
            default: begin
                state_d = DB_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DB_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Output decode.
    always_comb begin
        flag = (state_q == DB_TRIP);
    end

    // R7: a latched warning never drops while out of reset.
    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flag |=> flag);

    // R5: a warning rises only on a cycle that took a low valid sample.
    p_rise_on_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(smp_valid && is_low));

    // R5: the pending count stays below the trip length.
    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == DB_COUNT) |-> (cnt_q <= LAST) && (cnt_q != '0));

    // R6: a high valid sample before tripping restarts the count.
    p_clear_on_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !is_low && !flag) |=> (cnt_q == '0) && (state_q == DB_IDLE));

    // R6: idle cycles leave the count alone.
    p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_valid && !flag) |=> $stable(cnt_q));

endmodule

// File: rtl/edv_monitor.sv
`timescale 1ns/1ps
module edv_monitor
    import edv_pkg::*;
#(
    parameter int         CODE_W    = 8,
    parameter logic [7:0] RST_LEVEL = 8'hA2,
    parameter int         OFFSET    = 21,
    parameter int         TRIP_LEN  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [CODE_W-1:0] smp_code,
    input  logic              thr_wr,
    input  logic [CODE_W-1:0] thr_wdata,
    output logic [CODE_W-1:0] thr_level,
    output logic              warn_first,
    output logic              warn_final
);
    logic [CODE_W-1:0] thr_lane [LANES];
    logic [LANES-1:0]  low_lane;
    logic [LANES-1:0]  flag_lane;
    logic [CODE_W-1:0] thr_first_w, thr_final_w;

    edv_thr_reg #(
        .CODE_W    (CODE_W),
        .RST_LEVEL (RST_LEVEL),
        .OFFSET    (OFFSET)
    ) u_thr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (thr_wr),
        .wr_data   (thr_wdata),
        .thr_first (thr_first_w),
        .thr_final (thr_final_w)
    );

    assign thr_lane[LANE_FIRST] = thr_first_w;
    assign thr_lane[LANE_FINAL] = thr_final_w;

    // One strict less-than compare and one debounce machine per threshold.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign low_lane[g] = (smp_code < thr_lane[g]);

        edv_debounce #(
            .TRIP_LEN (TRIP_LEN)
        ) u_db (
            .clk       (clk),
            .rst_n     (rst_n),
            .smp_valid (smp_valid),
            .is_low    (low_lane[g]),
            .flag      (flag_lane[g])
        );
    end

    assign thr_level  = thr_first_w;
    assign warn_first = flag_lane[LANE_FIRST];
    assign warn_final = flag_lane[LANE_FINAL];

    // R8: the final warning implies the first warning.
    p_final_implies_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        warn_final |-> warn_first);

    // R4: the final threshold never exceeds the first.
    p_final_le_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        thr_final_w <= thr_first_w);

endmodule

// File: tb/edv_monitor_bench.sv
`timescale 1ns/1ps
module edv_monitor_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_valid = 1'b0;
    logic [7:0] smp_code = '0;
    logic       thr_wr = 1'b0;
    logic [7:0] thr_wdata = '0;
    logic [7:0] thr_level;
    logic       warn_first, warn_final;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    edv_monitor u_edv_monitor (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_code(smp_code),
        .thr_wr(thr_wr), .thr_wdata(thr_wdata), .thr_level(thr_level),
        .warn_first(warn_first), .warn_final(warn_final)
    );

    // {valid, code, expected warn_first, expected warn_final}; threshold A2h, final 141.
    localparam logic [10:0] VEC [0:27] = '{
        {1'b1, 8'd150, 1'b0, 1'b0}, {1'b1, 8'd150, 1'b0, 1'b0},
        {1'b1, 8'd150, 1'b0, 1'b0}, {1'b1, 8'd150, 1'b0, 1'b0},
        {1'b1, 8'd150, 1'b0, 1'b0}, {1'b1, 8'd150, 1'b0, 1'b0},
        {1'b1, 8'd150, 1'b0, 1'b0},
        {1'b1, 8'd162, 1'b0, 1'b0},
        {1'b0, 8'd10,  1'b0, 1'b0},
        {1'b1, 8'd150, 1'b0, 1'b0}, {1'b1, 8'd150, 1'b0, 1'b0},
        {1'b1, 8'd150, 1'b0, 1'b0}, {1'b1, 8'd150, 1'b0, 1'b0},
        {1'b1, 8'd150, 1'b0, 1'b0}, {1'b1, 8'd150, 1'b0, 1'b0},
        {1'b1, 8'd150, 1'b0, 1'b0},
        {1'b0, 8'd150, 1'b0, 1'b0},
        {1'b1, 8'd161, 1'b1, 1'b0},
        {1'b1, 8'd200, 1'b1, 1'b0},
        {1'b1, 8'd140, 1'b1, 1'b0}, {1'b1, 8'd140, 1'b1, 1'b0},
        {1'b1, 8'd140, 1'b1, 1'b0}, {1'b1, 8'd140, 1'b1, 1'b0},
        {1'b1, 8'd140, 1'b1, 1'b0}, {1'b1, 8'd140, 1'b1, 1'b0},
        {1'b1, 8'd140, 1'b1, 1'b0},
        {1'b1, 8'd140, 1'b1, 1'b1},
        {1'b1, 8'd255, 1'b1, 1'b1}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one cycle of inputs, then sample just after the edge.
    task automatic step(input bit v, input logic [7:0] code, input bit wr, input logic [7:0] wd);
        @(negedge clk);
        smp_valid = v; smp_code = code; thr_wr = wr; thr_wdata = wd;
        @(posedge clk);
        #1;
        smp_valid = 1'b0; thr_wr = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=1 expected=0");
            summary();
        end
    end

    initial begin
        do_reset();
        #1;
        check("R1 thr_level", int'(thr_level), 8'hA2);
        check("R1 warn_first", int'(warn_first), 0);
        check("R1 warn_final", int'(warn_final), 0);

        // Table: R3 equality, R5 trip edge, R6 restart and idle hold, R7 sticky, R8.
        foreach (VEC[i]) begin
            step(VEC[i][10], VEC[i][9:2], 1'b0, 8'h00);
            check($sformatf("R5/R6/R3 vec%0d warn_first", i), int'(warn_first), int'(VEC[i][1]));
            check($sformatf("R5/R7/R8 vec%0d warn_final", i), int'(warn_final), int'(VEC[i][0]));
        end

        // R7: a threshold write does not clear latched warnings.
        step(1'b0, 8'd0, 1'b1, 8'hFF);
        check("R7 after write warn_first", int'(warn_first), 1);
        check("R7 after write warn_final", int'(warn_final), 1);

        // R1 / R7: reset clears the warnings and restores the threshold.
        do_reset();
        #1;
        check("R1 reset thr_level", int'(thr_level), 8'hA2);
        check("R7 reset warn_first", int'(warn_first), 0);
        check("R7 reset warn_final", int'(warn_final), 0);

        // R4: threshold 16 clamps the final level to 0, so only the first warning sets.
        step(1'b0, 8'd0, 1'b1, 8'h10);
        check("R2 write thr_level", int'(thr_level), 8'h10);
        for (int k = 0; k < 16; k++) step(1'b1, 8'd0, 1'b0, 8'h00);
        check("R4 clamp warn_first", int'(warn_first), 1);
        check("R4 clamp warn_final", int'(warn_final), 0);

        // R4: threshold 21 gives final level 0 (boundary).
        do_reset();
        step(1'b0, 8'd0, 1'b1, 8'd21);
        for (int k = 0; k < 8; k++) step(1'b1, 8'd0, 1'b0, 8'h00);
        check("R4 thr21 warn_final", int'(warn_final), 0);

        // R4: threshold 22 gives final level 1; code 0 is below it.
        do_reset();
        step(1'b0, 8'd0, 1'b1, 8'd22);
        for (int k = 0; k < 7; k++) step(1'b1, 8'd0, 1'b0, 8'h00);
        check("R5 thr22 7th warn_final", int'(warn_final), 0);
        step(1'b1, 8'd0, 1'b0, 8'h00);
        check("R4 thr22 8th warn_final", int'(warn_final), 1);
        check("R8 thr22 warn_first", int'(warn_first), 1);

        // R2: a sample on the same edge as a write uses the old threshold.
        do_reset();
        for (int k = 0; k < 7; k++) step(1'b1, 8'd100, 1'b0, 8'h00);
        step(1'b1, 8'd100, 1'b1, 8'd50);
        check("R2 old-threshold sample warn_first", int'(warn_first), 1);
        check("R2 new thr_level", int'(thr_level), 50);

        done = 1'b1;
        summary();
    end
endmodule